// File: doc/BRIEF.md
# Burst-Mode Coarse Frequency Acquisition Loop

This block is the integer (coarse) tuning loop of a duty-cycled all-digital PLL. It runs on the reference clock. It lets the oscillator run in short bursts, and each burst is exactly one reference cycle long, once every ten reference cycles. While a burst is open, a counter clocked by the oscillator counts its rising edges. When the burst closes, the frozen count crosses into the reference domain on a toggle flag with a two-flop synchronizer. The count is then compared against the frequency control word, which is the wanted output frequency divided by the reference frequency.

The difference (word minus count) is scaled down by a programmable arithmetic right shift and added to a saturating 7-bit tuning code. The tuning code feeds the oscillator DAC for the next burst and is held constant between bursts. A count equal to the control word, or to the control word plus one, is treated as zero error. Three zero-error bursts in a row raise a coarse-lock flag, and the first burst with a nonzero error drops it.

The reference-domain sequencer is a four-state machine:
- SEQ_IDLE waits for the phase counter to reach its last value and then moves to SEQ_BURST.
- SEQ_BURST always lasts one cycle, with the enable high, and then moves to SEQ_WAIT.
- SEQ_WAIT holds until the synchronized ready event arrives and then moves to SEQ_APPLY.
- SEQ_APPLY updates the code and lock for one cycle and then returns to SEQ_IDLE.

Top module: `coarse_freq_loop`

## Requirements
- R1: While reset is asserted and right after it, `tune_code` is 64, `coarse_lock` is 0 and `osc_en` is 0.
- R2: `osc_en` first goes high in the cycle that follows the 10th rising edge of `ref_clk` after reset is released. It is high for exactly one reference cycle and then repeats every 10 reference cycles.
- R3: The edge count of a burst is the number of rising edges of `osc_clk` that occur while `osc_en` is high.
- R4: After each burst, the error is `fcw` minus the count. It is arithmetically shifted right by `gain_shift` (0 to 3), rounding toward minus infinity, and added to `tune_code`. The new code is visible no later than 6 reference cycles after `osc_en` falls.
- R5: A count equal to `fcw` or to `fcw`+1 counts as zero error and leaves `tune_code` unchanged.
- R6: The updated code saturates at 0 and at 127 and never wraps.
- R7: `tune_code` does not change during a burst, nor in the cycle right after it. It changes at most once per burst.
- R8: `coarse_lock` rises on the update of the third consecutive zero-error burst and falls on the update of the first burst with a nonzero error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_clk | input | 1 | Oscillator clock whose edges are counted |
| fcw | input | 8 | Frequency control word (expected edges per burst) |
| gain_shift | input | 2 | Right shift applied to the error (0 to 3) |
| tune_code | output | 7 | Oscillator tuning code, held between bursts |
| osc_en | output | 1 | Burst enable, high for one reference cycle |
| coarse_lock | output | 1 | Coarse loop locked |

## Verification
A miscounted burst, a wrong error sign or a wrong shift shows up at `tune_code` within six reference cycles after `osc_en` falls. The code then drifts from the bench's model by a predictable step on every later burst. A wrong phase counter shows at `osc_en` as a first burst or a spacing that is off by cycles. A wrong zero-error band or lock streak shows as `coarse_lock` out of step with the modelled run of zero-error bursts, or as a code that moves by one when it should hold.

// File: rtl/cfl_pkg.sv
package cfl_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_BURST = 2'd1,
        SEQ_WAIT  = 2'd2,
        SEQ_APPLY = 2'd3
    } seq_state_t;

endpackage

// File: rtl/cfl_burst_seq.sv
module cfl_burst_seq
    import cfl_pkg::*;
#(
    parameter int PERIOD = 10
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic ready_evt,
    output logic osc_en,
    output logic apply
);

    localparam int PH_W  = $clog2(PERIOD);
    localparam int GAP_W = $clog2(PERIOD + 1) + 1;
    localparam logic [PH_W-1:0]  PH_LAST = PH_W'(PERIOD - 1);
    localparam logic [PH_W-1:0]  PH_ONE  = PH_W'(1);
    localparam logic [GAP_W-1:0] GAP_MAX = '1;
    localparam logic [GAP_W-1:0] GAP_ONE = GAP_W'(1);
    localparam logic [GAP_W-1:0] GAP_EXP = GAP_W'(PERIOD - 1);

    seq_state_t state_q, state_nx;
    logic [PH_W-1:0] phase_q;

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (phase_q == PH_LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + PH_ONE;
        end
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            SEQ_IDLE:  if (phase_q == PH_LAST) state_nx = SEQ_BURST;
            SEQ_BURST: state_nx = SEQ_WAIT;
            SEQ_WAIT:  if (ready_evt) state_nx = SEQ_APPLY;
            SEQ_APPLY: state_nx = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            osc_en <= 1'b0;
            apply  <= 1'b0;
        end else begin
            osc_en <= (state_nx == SEQ_BURST);
            apply  <= (state_nx == SEQ_APPLY);
        end
    end

    logic [GAP_W-1:0] gap_q;
    logic             seen_q;

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (osc_en) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != GAP_MAX) begin
            gap_q  <= gap_q + GAP_ONE;
        end
    end

    // R2
    burst_one_cycle_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        osc_en |=> !osc_en);

    // R2
    burst_spacing_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        ($rose(osc_en) && seen_q) |-> (gap_q == GAP_EXP));

    // R4
    apply_outside_burst_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        apply |-> !osc_en);

endmodule

// File: rtl/cfl_edge_count.sv
module cfl_edge_count #(
    parameter int CNT_W = 8
) (
    input  logic             osc_clk,
    input  logic             rst_n,
    input  logic             osc_en,
    output logic [CNT_W-1:0] count,
    output logic             rdy_tgl
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic en_q;

    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            count   <= '0;
            rdy_tgl <= 1'b0;
        end else begin
            en_q <= osc_en;
            if (osc_en && !en_q) begin
                count <= CNT_ONE;
            end else if (osc_en && (count != CNT_MAX)) begin
                count <= count + CNT_ONE;
            end
            if (!osc_en && en_q) begin
                rdy_tgl <= ~rdy_tgl;
            end
        end
    end

    // R3
    count_frozen_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (!osc_en && !en_q) |=> $stable(count));

endmodule

// File: rtl/cfl_toggle_sync.sv
module cfl_toggle_sync (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic tgl_in,
    output logic evt
);

    logic [2:0] sync_q;

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[1:0], tgl_in};
        end
    end

    assign evt = sync_q[2] ^ sync_q[1];

endmodule

// File: rtl/cfl_code_acc.sv
module cfl_code_acc #(
    parameter int CNT_W    = 8,
    parameter int CODE_W   = 7,
    parameter int SHIFT_W  = 2,
    parameter int LOCK_RUN = 3
) (
    input  logic               ref_clk,
    input  logic               rst_n,
    input  logic               apply,
    input  logic [CNT_W-1:0]   count,
    input  logic [CNT_W-1:0]   fcw,
    input  logic [SHIFT_W-1:0] gain_shift,
    output logic [CODE_W-1:0]  tune_code,
    output logic               coarse_lock
);

    localparam int ERR_W = CNT_W + 2;
    localparam int SUM_W = ((CNT_W > CODE_W) ? CNT_W : CODE_W) + 3;
    localparam int RUN_W = $clog2(LOCK_RUN + 1);
    localparam logic [CODE_W-1:0]       CODE_MID = CODE_W'(2 ** (CODE_W - 1));
    localparam logic [CODE_W-1:0]       CODE_TOP = '1;
    localparam logic signed [SUM_W-1:0] SUM_TOP  = SUM_W'(2 ** CODE_W - 1);
    localparam logic [CNT_W:0]          WIDE_ONE = (CNT_W + 1)'(1);
    localparam logic [RUN_W-1:0]        RUN_ONE  = RUN_W'(1);
    localparam logic [RUN_W-1:0]        RUN_FULL = RUN_W'(LOCK_RUN);

    logic                    in_band;
    logic signed [ERR_W-1:0] err_raw, err_eff, err_sc;
    logic signed [SUM_W-1:0] code_ext, err_ext, sum;
    logic [CODE_W-1:0]       code_nx;
    logic [RUN_W-1:0]        run_q;
    logic [RUN_W-1:0]        run_nx;

    assign in_band  = (count == fcw) || ({1'b0, count} == ({1'b0, fcw} + WIDE_ONE));
    assign err_raw  = $signed({2'b00, fcw}) - $signed({2'b00, count});
    assign err_eff  = in_band ? '0 : err_raw;
    assign err_sc   = err_eff >>> gain_shift;
    assign code_ext = $signed({{(SUM_W - CODE_W){1'b0}}, tune_code});
    assign err_ext  = $signed({{(SUM_W - ERR_W){err_sc[ERR_W-1]}}, err_sc});
    assign sum      = code_ext + err_ext;

    always_comb begin
        if (sum < 0) begin
            code_nx = '0;
        end else if (sum > SUM_TOP) begin
            code_nx = CODE_TOP;
        end else begin
            code_nx = sum[CODE_W-1:0];
        end
    end

    assign run_nx = !in_band ? '0 : ((run_q == RUN_FULL) ? run_q : run_q + RUN_ONE);

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            tune_code   <= CODE_MID;
            run_q       <= '0;
            coarse_lock <= 1'b0;
        end else if (apply) begin
            tune_code   <= code_nx;
            run_q       <= run_nx;
            coarse_lock <= (run_nx == RUN_FULL);
        end
    end

    // R7
    code_hold_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !apply |=> $stable(tune_code));

    // R5
    band_hold_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (apply && in_band) |=> $stable(tune_code));

    // R8
    lock_clear_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (apply && !in_band) |=> !coarse_lock);

    // R8
    lock_rise_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(coarse_lock) |-> $past(apply));

endmodule

// File: rtl/coarse_freq_loop.sv
module coarse_freq_loop #(
    parameter int CNT_W        = 8,
    parameter int CODE_W       = 7,
    parameter int SHIFT_W      = 2,
    parameter int BURST_PERIOD = 10,
    parameter int LOCK_RUN     = 3
) (
    input  logic               ref_clk,
    input  logic               rst_n,
    input  logic               osc_clk,
    input  logic [CNT_W-1:0]   fcw,
    input  logic [SHIFT_W-1:0] gain_shift,
    output logic [CODE_W-1:0]  tune_code,
    output logic               osc_en,
    output logic               coarse_lock
);

    logic             apply;
    logic             ready_evt;
    logic             rdy_tgl;
    logic [CNT_W-1:0] burst_count;

    cfl_burst_seq #(.PERIOD(BURST_PERIOD)) u_seq (
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .ready_evt (ready_evt),
        .osc_en    (osc_en),
        .apply     (apply)
    );

    cfl_edge_count #(.CNT_W(CNT_W)) u_cnt (
        .osc_clk (osc_clk),
        .rst_n   (rst_n),
        .osc_en  (osc_en),
        .count   (burst_count),
        .rdy_tgl (rdy_tgl)
    );

    cfl_toggle_sync u_sync (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .tgl_in  (rdy_tgl),
        .evt     (ready_evt)
    );

    cfl_code_acc #(
        .CNT_W    (CNT_W),
        .CODE_W   (CODE_W),
        .SHIFT_W  (SHIFT_W),
        .LOCK_RUN (LOCK_RUN)
    ) u_acc (
        .ref_clk     (ref_clk),
        .rst_n       (rst_n),
        .apply       (apply),
        .count       (burst_count),
        .fcw         (fcw),
        .gain_shift  (gain_shift),
        .tune_code   (tune_code),
        .coarse_lock (coarse_lock)
    );

endmodule

// File: tb/sim_coarse_freq_loop.sv
`timescale 1ns/1ps
module sim_coarse_freq_loop;

    typedef struct packed {
        int n;
        int f;
        int sh;
        int bursts;
        int exp_code;
        int exp_lock;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t TBL [NV] = '{
        '{16, 20, 0, 2,  72, 0},
        '{16, 10, 1, 2,  66, 0},
        '{20, 15, 2, 1,  64, 0},
        '{10, 17, 3, 1,  64, 0},
        '{16, 16, 0, 3,  64, 1},
        '{16, 15, 0, 1,  64, 1},
        '{16, 17, 0, 1,  65, 0},
        '{ 8,200, 0, 2, 127, 0},
        '{50,  5, 0, 3,   0, 0},
        '{25, 24, 3, 3,   0, 1},
        '{10, 13, 1, 1,   1, 0}
    };

    logic       ref_clk = 1'b0;
    logic       osc_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic [7:0] fcw     = 8'd15;
    logic [1:0] gain_shift = 2'd0;
    logic [6:0] tune_code;
    logic       osc_en;
    logic       coarse_lock;

    real osc_per = 1.25;
    int  n_chk   = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    int  m_code  = 64;
    int  m_run   = 0;
    int  m_lock  = 0;

    coarse_freq_loop u0 (
        .ref_clk     (ref_clk),
        .rst_n       (rst_n),
        .osc_clk     (osc_clk),
        .fcw         (fcw),
        .gain_shift  (gain_shift),
        .tune_code   (tune_code),
        .osc_en      (osc_en),
        .coarse_lock (coarse_lock)
    );

    always #10 ref_clk = ~ref_clk;

    initial begin
        real hp;
        #0.013;
        forever begin
            hp = osc_per / 2.0;
            osc_clk = 1'b1;
            #(hp);
            osc_clk = 1'b0;
            #(hp);
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void mdl_step(input int n, input int f, input int sh);
        int e;
        int s;
        if (n == f || n == f + 1) e = 0;
        else e = f - n;
        s = m_code + (e >>> sh);
        if (s < 0) s = 0;
        if (s > 127) s = 127;
        m_code = s;
        if (e == 0) begin
            if (m_run < 3) m_run++;
        end else begin
            m_run = 0;
        end
        m_lock = (m_run >= 3) ? 1 : 0;
    endfunction

    task automatic one_burst();
        while (osc_en !== 1'b1) @(negedge ref_clk);
        check("R7", "code during burst", int'(tune_code), m_code);
        @(negedge ref_clk);
        check("R2", "enable width", int'(osc_en), 0);
        check("R7", "code just after burst", int'(tune_code), m_code);
        repeat (6) @(negedge ref_clk);
    endtask

    initial begin
        #(20.0 * 20000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int first_hi;
        int second_hi;
        repeat (3) @(negedge ref_clk);
        // R1 reset state
        check("R1", "code in reset", int'(tune_code), 64);
        check("R1", "lock in reset", int'(coarse_lock), 0);
        check("R1", "enable in reset", int'(osc_en), 0);
        rst_n = 1'b1;
        first_hi = 0;
        second_hi = 0;
        for (int i = 1; i <= 20; i++) begin
            @(negedge ref_clk);
            if (osc_en === 1'b1) begin
                if (first_hi == 0) first_hi = i;
                else second_hi = i;
            end
        end
        // R2 first burst after the tenth edge, then every ten
        check("R2", "first burst index", first_hi, 10);
        check("R2", "second burst index", second_hi, 20);
        @(negedge ref_clk);
        repeat (6) @(negedge ref_clk);
        mdl_step(16, 15, 0);
        mdl_step(16, 15, 0);
        // R5 count = fcw+1 leaves code alone
        check("R5", "code after in-band bursts", int'(tune_code), m_code);
        check("R8", "lock after two in-band bursts", int'(coarse_lock), m_lock);

        // R3 R4 R5 R6 R8 table walk
        for (int v = 0; v < NV; v++) begin
            fcw        = TBL[v].f[7:0];
            gain_shift = TBL[v].sh[1:0];
            osc_per    = 20.0 / real'(TBL[v].n);
            for (int b = 0; b < TBL[v].bursts; b++) begin
                one_burst();
                mdl_step(TBL[v].n, TBL[v].f, TBL[v].sh);
                check("R4", "code after burst", int'(tune_code), m_code);
                check("R8", "lock after burst", int'(coarse_lock), m_lock);
            end
            if (TBL[v].exp_code == 0 || TBL[v].exp_code == 127)
                check("R6", "saturated code", int'(tune_code), TBL[v].exp_code);
            else
                check("R3", "vector final code", int'(tune_code), TBL[v].exp_code);
            check("R8", "vector final lock", int'(coarse_lock), TBL[v].exp_lock);
        end

        // R1 mid-run reset
        @(negedge ref_clk);
        rst_n = 1'b0;
        @(negedge ref_clk);
        check("R1", "code after re-reset", int'(tune_code), 64);
        check("R1", "lock after re-reset", int'(coarse_lock), 0);
        check("R1", "enable after re-reset", int'(osc_en), 0);
        rst_n = 1'b1;
        first_hi = 0;
        for (int i = 1; i <= 12; i++) begin
            @(negedge ref_clk);
            if (osc_en === 1'b1 && first_hi == 0) first_hi = i;
        end
        check("R2", "first burst after re-reset", first_hi, 10);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule